// File: doc/BRIEF.md
# Double Carry-Save Adder/Subtractor

This block adds or subtracts two operands that are held in a redundant form with three bits per digit, and it returns the result in that same form. A digit's value is the plain count of its three set bits, so each digit holds a value from 0 to 3. Each digit of an operand carries weight 2^i. The logic never ripples a carry across the word. Each digit position has one counter with six inputs, which counts the three bits of the X digit and the three bits of the Y digit. The three output bits of that counter are then spread over its own digit and the two digits above it. The delay of the add path is one counter level, whatever the digit count.

A mode input selects subtraction. In that mode every bit of Y is inverted before it reaches the counters. The constant needed to complete the negation is injected through two low slots that would otherwise always be zero. The redundant result is registered. A carry-propagate converter then turns the registered value into plain binary, for datapaths that need a conventional number and for checking. All arithmetic wraps modulo 2^NDIG.

Top module: `dcs_addsub`

## Requirements
- R1: Digit i of an operand or result occupies bits [3i+2:3i], ordered {zc, zb, za} from high to low. Its value is za+zb+zc, weighted by 2^i.
- R2: sum_o and bin_o change only at a rising clock edge, and they then reflect the x_i, y_i and sub_i values sampled at that edge.
- R3: While rst_ni is low, sum_o and bin_o are all zeros, whatever the inputs are.
- R4: With sub_i = 0, the value of sum_o equals (X + Y) mod 2^NDIG.
- R5: With sub_i = 1, the value of sum_o equals (X - Y) mod 2^NDIG, including results that are negative and wrap.
- R6: Let c be the count (0 to 6) of the six set bits of digit i of X and of digit i of Y, where Y is inverted in subtract mode. Bit 0 of c goes to za of digit i, bit 1 goes to zb of digit i+1, and bit 2 goes to zc of digit i+2. Bits that would land above digit NDIG-1 are dropped, and zc of digit 0 is always 0.
- R7: zb of digit 0 (bit 1) and zc of digit 1 (bit 5) both equal sub_i, so they add 3 in subtract mode and 0 in add mode.
- R8: bin_o equals (Za + Zb + Zc) mod 2^NDIG, taken over the registered sum_o, where Za, Zb and Zc are the vectors of the za, zb and zc bits across all digits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | 3*NDIG | Redundant operand X |
| y_i | input | 3*NDIG | Redundant operand Y |
| sub_i | input | 1 | 1 selects X - Y, 0 selects X + Y |
| sum_o | output | 3*NDIG | Registered redundant result |
| bin_o | output | NDIG | Binary conversion of sum_o |

## Verification
The hardest cases to reach are digit counts of 5 and 6 in a position whose upper bits fall off the top of the word, and the same counts arriving alongside the subtract correction in the two lowest digits. In those cases a wiring slip is hidden unless the exact bit placement is compared. A two-digit instance is therefore swept over every pair of operand bit patterns in both modes, which covers every digit triple and every count in every position. A sixteen-digit instance runs at the same time on all-threes, zero and negative-result corner cases and then on random operands. For both instances the bench compares the exact redundant bits, the wrapped arithmetic value and the binary conversion.

// File: rtl/dcs_pkg.sv
`timescale 1ns/1ps
package dcs_pkg;
  localparam int unsigned DIG_W  = 3;          // bits per redundant digit
  localparam int unsigned CNT_IN = 2 * DIG_W;  // counter inputs per digit
  localparam int unsigned CNT_W  = 3;          // counter output width

  typedef struct packed {
    logic zc;
    logic zb;
    logic za;
  } dcs_digit_t;
endpackage

// File: rtl/dcs_count63.sv
`timescale 1ns/1ps
module dcs_count63
  import dcs_pkg::*;
(
  input  logic [CNT_IN-1:0] bits_i,
  output logic [CNT_W-1:0]  cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int k = 0; k < CNT_IN; k++) cnt_o = cnt_o + CNT_W'(bits_i[k]);
  end
endmodule

// File: rtl/dcs_operand_cond.sv
`timescale 1ns/1ps
module dcs_operand_cond
  import dcs_pkg::*;
#(
  parameter int unsigned NDIG = 16,
  localparam int unsigned RW  = DIG_W * NDIG
) (
  input  logic [RW-1:0] y_i,
  input  logic          sub_i,
  output logic [RW-1:0] y_o
);
  // one's complement of all three component vectors in subtract mode
  assign y_o = y_i ^ {RW{sub_i}};
endmodule

// File: rtl/dcs_digit_array.sv
`timescale 1ns/1ps
module dcs_digit_array
  import dcs_pkg::*;
#(
  parameter int unsigned NDIG = 16,
  localparam int unsigned RW  = DIG_W * NDIG
) (
  input  logic [RW-1:0] x_i,
  input  logic [RW-1:0] y_i,
  input  logic          corr_i,
  output logic [RW-1:0] red_o
);
  logic [CNT_W-1:0] cnt [NDIG];
  logic [NDIG-1:0]  za, zb, zc;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    dcs_count63 u_cnt (
      .bits_i({x_i[DIG_W*i +: DIG_W], y_i[DIG_W*i +: DIG_W]}),
      .cnt_o (cnt[i])
    );

    assign za[i] = cnt[i][0];

    if (i == 0) begin : g_b0
      assign zb[i] = corr_i;        // correction weight 1
    end else begin : g_bn
      assign zb[i] = cnt[i-1][1];
    end

    if (i == 0) begin : g_c0
      assign zc[i] = 1'b0;
    end else if (i == 1) begin : g_c1
      assign zc[i] = corr_i;        // correction weight 2
    end else begin : g_cn
      assign zc[i] = cnt[i-2][2];
    end

    dcs_digit_t dig;
    assign dig = '{zc: zc[i], zb: zb[i], za: za[i]};
    assign red_o[DIG_W*i +: DIG_W] = dig;
  end

  // bits shifted past the top digit wrap away
  logic unused_top;
  assign unused_top = ^{cnt[NDIG-1][2:1], cnt[NDIG-2][2]};
endmodule

// File: rtl/dcs_to_bin.sv
`timescale 1ns/1ps
module dcs_to_bin
  import dcs_pkg::*;
#(
  parameter int unsigned NDIG = 16,
  localparam int unsigned RW  = DIG_W * NDIG
) (
  input  logic [RW-1:0]   red_i,
  output logic [NDIG-1:0] bin_o
);
  logic [NDIG-1:0] va, vb, vc;

  for (genvar i = 0; i < NDIG; i++) begin : g_split
    dcs_digit_t dig;
    assign dig   = red_i[DIG_W*i +: DIG_W];
    assign va[i] = dig.za;
    assign vb[i] = dig.zb;
    assign vc[i] = dig.zc;
  end

  // ordinary carry-propagate sum, wraps modulo 2^NDIG
  assign bin_o = va + vb + vc;
endmodule

// File: rtl/dcs_addsub.sv
`timescale 1ns/1ps
module dcs_addsub
  import dcs_pkg::*;
#(
  parameter int unsigned NDIG = 16,
  localparam int unsigned RW  = DIG_W * NDIG
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RW-1:0]   x_i,
  input  logic [RW-1:0]   y_i,
  input  logic            sub_i,
  output logic [RW-1:0]   sum_o,
  output logic [NDIG-1:0] bin_o
);
  logic [RW-1:0] y_cond, sum_d, sum_q;

  dcs_operand_cond #(.NDIG(NDIG)) u_cond (
    .y_i  (y_i),
    .sub_i(sub_i),
    .y_o  (y_cond)
  );

  dcs_digit_array #(.NDIG(NDIG)) u_array (
    .x_i   (x_i),
    .y_i   (y_cond),
    .corr_i(sub_i),
    .red_o (sum_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else         sum_q <= sum_d;
  end

  dcs_to_bin #(.NDIG(NDIG)) u_bin (
    .red_i(sum_q),
    .bin_o(bin_o)
  );

  assign sum_o = sum_q;

  // digit-by-digit value, independent of the vector split used above
  function automatic logic [NDIG-1:0] red_val(input logic [RW-1:0] v);
    logic [NDIG-1:0] acc;
    acc = '0;
    for (int i = 0; i < NDIG; i++)
      acc = acc + ((NDIG'(v[DIG_W*i]) + NDIG'(v[DIG_W*i+1]) + NDIG'(v[DIG_W*i+2])) << i);
    return acc;
  endfunction

  logic [NDIG-1:0] x_val, y_val, q_val;
  assign x_val = red_val(x_i);
  assign y_val = red_val(y_i);
  assign q_val = red_val(sum_q);

  always @(posedge clk_i)
    if (!rst_ni) AST_RESET_ZERO: assert (sum_q == '0 && bin_o == '0); // R3

  AST_ADD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sub_i |=> q_val == NDIG'($past(x_val) + $past(y_val))); // R4

  AST_SUB_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_i |=> q_val == NDIG'($past(x_val) - $past(y_val))); // R5

  AST_CORR_SLOTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sum_q[1] == $past(sub_i)) && (sum_q[5] == $past(sub_i))); // R7

  AST_BIN_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bin_o == q_val); // R8
endmodule

// File: tb/dcs_addsub_test.sv
`timescale 1ns/1ps
module dcs_addsub_test;
  localparam int NS = 2;
  localparam int NW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  always #2.5 clk = ~clk;

  logic [3*NS-1:0] xs, ys, sum_s;
  logic [NS-1:0]   bin_s;
  logic            subs;
  logic [3*NW-1:0] xw, yw, sum_w;
  logic [NW-1:0]   bin_w;
  logic            subw;

  dcs_addsub #(.NDIG(NS)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .x_i(xs), .y_i(ys), .sub_i(subs),
    .sum_o(sum_s), .bin_o(bin_s)
  );

  dcs_addsub #(.NDIG(NW)) uut_wide (
    .clk_i(clk), .rst_ni(rst_ni), .x_i(xw), .y_i(yw), .sub_i(subw),
    .sum_o(sum_w), .bin_o(bin_w)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // R1: value = sum over digits of (za+zb+zc) * 2^i, wrapped to n bits
  function automatic longint unsigned dval(input logic [47:0] v, input int n);
    longint unsigned acc = 0;
    for (int i = 0; i < n; i++)
      acc += (longint'(v[3*i]) + longint'(v[3*i+1]) + longint'(v[3*i+2])) << i;
    return acc & ((64'd1 << n) - 1);
  endfunction

  // R6/R7: expected bit placement of the redundant result
  function automatic logic [47:0] dmodel(input logic [47:0] x, input logic [47:0] y,
                                         input bit sub, input int n);
    logic [47:0] r = '0;
    for (int i = 0; i < n; i++) begin
      logic [2:0] c;
      c = 3'($countones(x[3*i +: 3]) + $countones(y[3*i +: 3] ^ {3{sub}}));
      r[3*i] = c[0];
      if (i + 1 < n) r[3*(i+1)+1] = c[1];
      if (i + 2 < n) r[3*(i+2)+2] = c[2];
    end
    if (sub) begin
      r[1] = 1'b1;
      r[5] = 1'b1;
    end
    return r;
  endfunction

  task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_vec(input int n, input logic [47:0] x, input logic [47:0] y, input bit sub,
                         input logic [47:0] red, input longint unsigned bin);
    longint unsigned m = (64'd1 << n) - 1;
    longint unsigned eb;
    eb = sub ? ((dval(x, n) - dval(y, n)) & m) : ((dval(x, n) + dval(y, n)) & m);
    check("R6/R7 redundant digits", red, dmodel(x, y, sub, n));
    if (sub) check("R5 subtract value, R1 encoding", bin, eb);
    else     check("R4 add value, R1 encoding", bin, eb);
    check("R8 binary conversion", bin, dval(red, n));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int k;
    logic [47:0] ones;
    ones = '1;
    xs = '1; ys = '1; subs = 1'b1;
    xw = '1; yw = 48'h123456789abc; subw = 1'b0;
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R3 reset sum narrow", sum_s, 0);
    check("R3 reset bin narrow", bin_s, 0);
    check("R3 reset sum wide", sum_w, 0);
    check("R3 reset bin wide", bin_w, 0);

    @(negedge clk);
    rst_ni = 1'b1;
    xs = '0; ys = '0; subs = 1'b0;
    xw = '0; yw = '0; subw = 1'b0;
    @(negedge clk);
    xs = 6'b000001;
    #1 check("R2 no change before edge", sum_s, 0);
    @(posedge clk);
    #1 check("R2 update after edge", sum_s, 6'b000001);
    check("R2 binary after edge", bin_s, 1);

    k = 0;
    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 64; b++) begin
        for (int s = 0; s < 2; s++) begin
          @(negedge clk);
          xs = 6'(a); ys = 6'(b); subs = s[0];
          case (k)
            0: begin xw = ones; yw = ones; subw = 1'b0; end
            1: begin xw = ones; yw = ones; subw = 1'b1; end
            2: begin xw = '0;   yw = '0;   subw = 1'b0; end
            3: begin xw = '0;   yw = '0;   subw = 1'b1; end
            4: begin xw = '0;   yw = ones; subw = 1'b1; end
            5: begin xw = 48'h000000000001; yw = 48'h000000000009; subw = 1'b1; end
            6: begin xw = ones; yw = '0;   subw = 1'b1; end
            default: begin
              xw = 48'({$urandom(), $urandom()});
              yw = 48'({$urandom(), $urandom()});
              subw = $urandom() & 1;
            end
          endcase
          k++;
          @(posedge clk);
          #1;
          chk_vec(NS, 48'(xs), 48'(ys), subs, 48'(sum_s), 64'(bin_s));
          chk_vec(NW, xw, yw, subw, sum_w, 64'(bin_w));
        end
      end
    end
    done = 1;
    finish_run();
  end
endmodule